// File: doc/BRIEF.md
# Move Destination Decode and Writeback

This block is the write half of a register-to-register move in a small 16-bit microcontroller core. Each cycle in which a move is presented, it takes a 7-bit destination code, the source operand and a flag saying whether that operand is a byte. It decodes which architectural register the code names and applies the width conversion rules. It then loads the register, steps the pointer that the code uses, or issues a write request to data memory. The source-side decoder, instruction fetch and the memory itself live elsewhere, and memory is reached only through the registered write-request port.

The block holds the sixteen accumulators and their pointer, the stack pointer, two data pointers, the frame base and its 8-bit offset, the general register, two loop counters and eight byte-wide prefix registers. A move that writes a prefix register arms a one-move extension. During that next move the accumulator codes reach the upper bank, one frame code is reused for the general register's high byte, and a byte source widened to 16 bits takes its high byte from prefix register 0 instead of zero.

Top module: `mvdst_writeback`

## Requirements
- R1: After a synchronous active-low reset, every register output (pointers, offset, general register, loop counters, accumulator pointer, extension flag) reads zero and `mem_we` is low.
- R2: A word source written to a 16-bit destination is copied whole. A byte source written to a 16-bit destination outside the extension gets 00h as its high byte. A word source written to an 8-bit destination keeps only its low byte.
- R3: Code 0x76, and any code this block does not model (for example 0x48), changes no register and raises no memory write.
- R4: Code {n[2:0], 4'b1001} loads accumulator n. While the extension is armed it loads accumulator n+8 instead.
- R5: Code 0x08 loads the accumulator pointer from bits [3:0] of the source. Code 0x0A loads the accumulator that the pointer currently selects.
- R6: Code 0x0D adds one to the stack pointer and writes the converted value as a word to memory at the new stack pointer.
- R7: Codes 0x0E, 0x1E and 0x2E write memory at base + offset (offset zero-extended), with the offset unchanged, pre-incremented or pre-decremented (8-bit wrap). Code 0x3E loads the offset and 0x7E loads the base.
- R8: Code {s, m[1:0], 4'b1111} uses data pointer s. For m=00 it writes memory at the pointer, for m=01 it increments the pointer and then writes at it, for m=10 it decrements and then writes, and for m=11 it loads the pointer.
- R9: Code 0x5E loads the whole general register and 0x6E only its low byte. Under the extension, 0x1E loads only its high byte and leaves the frame offset unchanged.
- R10: Codes 0x6D and 0x7D load loop counters 0 and 1, and 0x1D loads the stack pointer.
- R11: Code {n[2:0], 4'b1011} loads prefix register n and arms the extension. The next move, of any kind, clears it. While the extension is armed, a byte source to a 16-bit destination takes prefix register 0 as its high byte.
- R12: A memory write appears on the port one cycle after its move, for one cycle. `mem_byte` is 1 for a byte source (data in bits [7:0], bits [15:8] zero) and 0 for a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mv_valid | input | 1 | A move is presented this cycle |
| mv_dst | input | 7 | Destination code |
| mv_src | input | 16 | Source operand |
| mv_src_byte | input | 1 | 1 when the source is 8 bits wide |
| acc_rd_idx | input | 4 | Accumulator read index for the source side |
| acc_rd_data | output | 16 | Accumulator selected by acc_rd_idx |
| ap_q | output | 4 | Accumulator pointer |
| sp_q | output | 16 | Stack pointer |
| bp_q | output | 16 | Frame base |
| offs_q | output | 8 | Frame offset |
| dp0_q | output | 16 | Data pointer 0 |
| dp1_q | output | 16 | Data pointer 1 |
| gr_q | output | 16 | General register |
| lc0_q | output | 16 | Loop counter 0 |
| lc1_q | output | 16 | Loop counter 1 |
| ext_q | output | 1 | Extension armed for the next move |
| mem_we | output | 1 | Memory write request |
| mem_byte | output | 1 | Request is a byte write |
| mem_addr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |

## Verification
The hardest condition to reach from the ports is the armed extension. It lasts for exactly one move and changes three separate things: the accumulator bank, the meaning of code 0x1E and the high-byte fill. The stimulus reaches it by writing a prefix register and then issuing the move under test at once. The same code is then repeated without the prefix write, which shows both that the extension took effect and that it was consumed. A prefix write followed by a null move shows that even a discarded move clears the extension.

// File: rtl/mvd_pkg.sv
// Shared types for the move destination writeback block.
// Assumes a 16-bit data path with byte-wide prefix registers.
package mvd_pkg;
    localparam int DW      = 16;
    localparam int BW      = 8;
    localparam int NUM_ACC = 16;
    localparam int AW      = $clog2(NUM_ACC);
    localparam int NUM_PFX = 8;
    localparam int PW      = $clog2(NUM_PFX);
    localparam int NUM_DP  = 2;
    localparam int NUM_LC  = 2;
    localparam int OW      = 8;

    typedef enum logic [3:0] {
        DK_NONE, DK_ACC_IDX, DK_ACC_ACT, DK_AP, DK_PFX, DK_SP_PUSH,
        DK_SP, DK_LC, DK_FRM_MEM, DK_OFFS, DK_BP, DK_GR, DK_GRL,
        DK_GRH, DK_DP_MEM, DK_DP
    } dst_kind_e;

    typedef enum logic [1:0] {STEP_NONE, STEP_INC, STEP_DEC} step_e;

    typedef struct packed {
        dst_kind_e  kind;
        step_e      step;
        logic [3:0] idx;
        logic       wide;   // memory write is a word
    } dst_dec_t;
endpackage

// File: rtl/mvd_decode.sv
// Destination decoder: maps a 7-bit code plus the extension flag to a
// destination kind, a pointer step, an index and the memory write width.
// Assumes the low nibble selects the group and the high three bits the
// index or mode. Codes that are not modelled decode to DK_NONE.
module mvd_decode
    import mvd_pkg::*;
(
    input  logic [6:0] code,
    input  logic       ext,
    input  logic       src_byte,
    output dst_dec_t   dec
);
    logic [2:0] hi;
    logic [3:0] lo;
    assign hi = code[6:4];
    assign lo = code[3:0];

    // Combinational group and mode decode.
    always_comb begin
        dec      = '{kind: DK_NONE, step: STEP_NONE, idx: 4'd0, wide: 1'b1};
        dec.wide = !src_byte;
        unique case (lo)
            4'b1001: begin
                dec.kind = DK_ACC_IDX;
                dec.idx  = {ext, hi};
            end
            4'b1010: if (!ext && hi == 3'b000) dec.kind = DK_ACC_ACT;
            4'b1000: if (!ext && hi == 3'b000) dec.kind = DK_AP;
            4'b1011: begin
                dec.kind = DK_PFX;
                dec.idx  = {1'b0, hi};
            end
            4'b1101: begin
                if (!ext) begin
                    if (hi == 3'b000) begin
                        dec.kind = DK_SP_PUSH;
                        dec.wide = 1'b1;
                    end else if (hi == 3'b001) begin
                        dec.kind = DK_SP;
                    end else if (hi[2:1] == 2'b11) begin
                        dec.kind = DK_LC;
                        dec.idx  = {3'b000, hi[0]};
                    end
                end
            end
            4'b1110: begin
                if (ext) begin
                    if (hi == 3'b001) dec.kind = DK_GRH;
                end else begin
                    unique case (hi)
                        3'b000: dec.kind = DK_FRM_MEM;
                        3'b001: begin
                            dec.kind = DK_FRM_MEM;
                            dec.step = STEP_INC;
                        end
                        3'b010: begin
                            dec.kind = DK_FRM_MEM;
                            dec.step = STEP_DEC;
                        end
                        3'b011: dec.kind = DK_OFFS;
                        3'b101: dec.kind = DK_GR;
                        3'b110: dec.kind = DK_GRL;
                        3'b111: dec.kind = DK_BP;
                        default: dec.kind = DK_NONE;
                    endcase
                end
            end
            4'b1111: begin
                if (!ext) begin
                    dec.idx = {3'b000, hi[2]};
                    unique case (hi[1:0])
                        2'b00: dec.kind = DK_DP_MEM;
                        2'b01: begin
                            dec.kind = DK_DP_MEM;
                            dec.step = STEP_INC;
                        end
                        2'b10: begin
                            dec.kind = DK_DP_MEM;
                            dec.step = STEP_DEC;
                        end
                        default: dec.kind = DK_DP;
                    endcase
                end
            end
            default: dec.kind = DK_NONE;
        endcase
    end
endmodule

// File: rtl/mvd_width.sv
// Width converter: builds the 16-bit image of the source for 16-bit
// destinations and the byte image for 8-bit destinations.
// Assumes the high fill comes from prefix register 0 while the
// extension is armed, and is zero otherwise.
module mvd_width
    import mvd_pkg::*;
(
    input  logic [DW-1:0] src,
    input  logic          src_byte,
    input  logic          ext,
    input  logic [BW-1:0] pfx_hi,
    output logic [DW-1:0] word,
    output logic [BW-1:0] byte8
);
    logic [DW-BW-1:0] fill;

    // Select the high byte used when a byte is widened.
    always_comb fill = ext ? pfx_hi : '0;

    // Form the word and byte images.
    always_comb begin
        word  = src_byte ? {fill, src[BW-1:0]} : src;
        byte8 = src[BW-1:0];
    end
endmodule

// File: rtl/mvd_regs.sv
// Register bank: accumulators, accumulator pointer, general register,
// loop counters and prefix registers. Writes take effect at the clock
// edge of the move. Assumes a decoded kind and index from mvd_decode.
module mvd_regs
    import mvd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  dst_kind_e     kind,
    input  logic [3:0]    idx,
    input  logic [DW-1:0] word,
    input  logic [BW-1:0] byte8,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] ap_q,
    output logic [DW-1:0] gr_q,
    output logic [DW-1:0] lc0_q,
    output logic [DW-1:0] lc1_q,
    output logic [BW-1:0] pfx0_q
);
    logic [DW-1:0] acc_q [NUM_ACC];
    logic [DW-1:0] lc_q  [NUM_LC];
    logic [BW-1:0] pfx_q [NUM_PFX];

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        logic hit;
        // Accumulator g is hit by its index code or as the active one.
        always_comb hit = wr_en &&
            ((kind == DK_ACC_IDX && idx[AW-1:0] == AW'(g)) ||
             (kind == DK_ACC_ACT && ap_q == AW'(g)));
        // Load accumulator g.
        always_ff @(posedge clk) begin
            if (!rst_n)   acc_q[g] <= '0;
            else if (hit) acc_q[g] <= word;
        end
    end

    for (genvar g = 0; g < NUM_LC; g++) begin : g_lc
        // Load loop counter g.
        always_ff @(posedge clk) begin
            if (!rst_n) lc_q[g] <= '0;
            else if (wr_en && kind == DK_LC && idx[0] == 1'(g)) lc_q[g] <= word;
        end
    end

    for (genvar g = 0; g < NUM_PFX; g++) begin : g_pfx
        // Load prefix register g.
        always_ff @(posedge clk) begin
            if (!rst_n) pfx_q[g] <= '0;
            else if (wr_en && kind == DK_PFX && idx[PW-1:0] == PW'(g)) pfx_q[g] <= byte8;
        end
    end

    // Accumulator pointer takes the low bits of the byte image.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ap_q <= '0;
        else if (wr_en && kind == DK_AP) ap_q <= byte8[AW-1:0];
    end

    // General register: whole word or one byte half.
    always_ff @(posedge clk) begin
        if (!rst_n) gr_q <= '0;
        else if (wr_en) begin
            unique case (kind)
                DK_GR:   gr_q <= word;
                DK_GRL:  gr_q[BW-1:0] <= byte8;
                DK_GRH:  gr_q[DW-1:BW] <= byte8;
                default: ;
            endcase
        end
    end

    assign rd_data = acc_q[rd_idx];
    assign lc0_q   = lc_q[0];
    assign lc1_q   = lc_q[1];
    assign pfx0_q  = pfx_q[0];

    AST_GRL_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && kind == DK_GRL |=> gr_q[DW-1:BW] == $past(gr_q[DW-1:BW])); // R9
    AST_GRH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && kind == DK_GRH |=> gr_q[BW-1:0] == $past(gr_q[BW-1:0])); // R9
    AST_NONE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && kind == DK_NONE |=> $stable(gr_q) && $stable(ap_q)); // R3
endmodule

// File: rtl/mvd_ptrs.sv
// Pointer unit: stack pointer, frame base and offset, data pointers and
// the registered memory write request. A pre-step and the write happen
// on the same edge; the issued address is the stepped pointer value.
module mvd_ptrs
    import mvd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  dst_kind_e     kind,
    input  step_e         step,
    input  logic          sel,
    input  logic          wide,
    input  logic [DW-1:0] word,
    input  logic [BW-1:0] byte8,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] bp_q,
    output logic [OW-1:0] offs_q,
    output logic [DW-1:0] dp0_q,
    output logic [DW-1:0] dp1_q,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    logic [DW-1:0] dp_q [NUM_DP];
    logic [DW-1:0] dp_n [NUM_DP];
    logic [DW-1:0] sp_n, bp_n, addr_n;
    logic [OW-1:0] offs_n;
    logic          req;

    // Next pointer values and the request for this move.
    always_comb begin
        sp_n   = sp_q;
        bp_n   = bp_q;
        offs_n = offs_q;
        for (int i = 0; i < NUM_DP; i++) dp_n[i] = dp_q[i];
        req    = 1'b0;
        addr_n = '0;
        if (wr_en) begin
            unique case (kind)
                DK_SP_PUSH: begin
                    sp_n   = sp_q + 1'b1;
                    req    = 1'b1;
                    addr_n = sp_n;
                end
                DK_SP:   sp_n = word;
                DK_BP:   bp_n = word;
                DK_OFFS: offs_n = byte8;
                DK_FRM_MEM: begin
                    if (step == STEP_INC)      offs_n = offs_q + 1'b1;
                    else if (step == STEP_DEC) offs_n = offs_q - 1'b1;
                    req    = 1'b1;
                    addr_n = bp_q + DW'(offs_n);
                end
                DK_DP: dp_n[sel] = word;
                DK_DP_MEM: begin
                    if (step == STEP_INC)      dp_n[sel] = dp_q[sel] + 1'b1;
                    else if (step == STEP_DEC) dp_n[sel] = dp_q[sel] - 1'b1;
                    req    = 1'b1;
                    addr_n = dp_n[sel];
                end
                default: ;
            endcase
        end
    end

    // Pointer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            bp_q   <= '0;
            offs_q <= '0;
        end else begin
            sp_q   <= sp_n;
            bp_q   <= bp_n;
            offs_q <= offs_n;
        end
    end

    for (genvar g = 0; g < NUM_DP; g++) begin : g_dp
        // Data pointer g.
        always_ff @(posedge clk) begin
            if (!rst_n) dp_q[g] <= '0;
            else        dp_q[g] <= dp_n[g];
        end
    end

    // Registered memory write request, one cycle after the move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_byte  <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= req;
            mem_byte  <= req && !wide;
            mem_addr  <= addr_n;
            mem_wdata <= wide ? word : {{(DW-BW){1'b0}}, byte8};
        end
    end

    assign dp0_q = dp_q[0];
    assign dp1_q = dp_q[1];

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && kind == DK_SP_PUSH |=>
            mem_we && !mem_byte && sp_q == $past(sp_q) + 16'd1 && mem_addr == sp_q); // R6
    AST_FRAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && kind == DK_FRM_MEM |=> mem_we && mem_addr == bp_q + DW'(offs_q)); // R7
    AST_WE_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wr_en)); // R12
    AST_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && mem_byte |-> mem_wdata[DW-1:BW] == '0); // R12
    AST_IDLE_KEEPS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sp_q) && $stable(offs_q) && $stable(dp0_q) && !mem_we); // R3
endmodule

// File: rtl/mvdst_writeback.sv
// Top of the move destination writeback. Holds the one-move extension
// flag, which a prefix write arms and any following move consumes, and
// connects decoder, width converter, register bank and pointer unit.
module mvdst_writeback
    import mvd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mv_valid,
    input  logic [6:0]    mv_dst,
    input  logic [15:0]   mv_src,
    input  logic          mv_src_byte,
    input  logic [3:0]    acc_rd_idx,
    output logic [15:0]   acc_rd_data,
    output logic [3:0]    ap_q,
    output logic [15:0]   sp_q,
    output logic [15:0]   bp_q,
    output logic [7:0]    offs_q,
    output logic [15:0]   dp0_q,
    output logic [15:0]   dp1_q,
    output logic [15:0]   gr_q,
    output logic [15:0]   lc0_q,
    output logic [15:0]   lc1_q,
    output logic          ext_q,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [15:0]   mem_addr,
    output logic [15:0]   mem_wdata
);
    dst_dec_t      dec;
    logic [DW-1:0] word;
    logic [BW-1:0] byte8;
    logic [BW-1:0] pfx0;

    mvd_decode u_decode (
        .code     (mv_dst),
        .ext      (ext_q),
        .src_byte (mv_src_byte),
        .dec      (dec)
    );

    mvd_width u_width (
        .src      (mv_src),
        .src_byte (mv_src_byte),
        .ext      (ext_q),
        .pfx_hi   (pfx0),
        .word     (word),
        .byte8    (byte8)
    );

    mvd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mv_valid),
        .kind    (dec.kind),
        .idx     (dec.idx),
        .word    (word),
        .byte8   (byte8),
        .rd_idx  (acc_rd_idx),
        .rd_data (acc_rd_data),
        .ap_q    (ap_q),
        .gr_q    (gr_q),
        .lc0_q   (lc0_q),
        .lc1_q   (lc1_q),
        .pfx0_q  (pfx0)
    );

    mvd_ptrs u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mv_valid),
        .kind      (dec.kind),
        .step      (dec.step),
        .sel       (dec.idx[0]),
        .wide      (dec.wide),
        .word      (word),
        .byte8     (byte8),
        .sp_q      (sp_q),
        .bp_q      (bp_q),
        .offs_q    (offs_q),
        .dp0_q     (dp0_q),
        .dp1_q     (dp1_q),
        .mem_we    (mem_we),
        .mem_byte  (mem_byte),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Extension flag: armed by a prefix write, consumed by the next move.
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_q <= 1'b0;
        else if (mv_valid) ext_q <= (dec.kind == DK_PFX);
    end

    AST_EXT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid && mv_dst[3:0] != 4'b1011 |=> !ext_q); // R11
    AST_EXT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid && mv_dst[3:0] == 4'b1011 |=> ext_q); // R11
    AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_valid |=> $stable(ext_q)); // R11
endmodule

// File: tb/test_mvdst_writeback.sv
module test_mvdst_writeback;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mv_valid = 1'b0;
    logic [6:0]  mv_dst = '0;
    logic [15:0] mv_src = '0;
    logic        mv_src_byte = 1'b0;
    logic [3:0]  acc_rd_idx = '0;
    logic [15:0] acc_rd_data;
    logic [3:0]  ap_q;
    logic [15:0] sp_q, bp_q, dp0_q, dp1_q, gr_q, lc0_q, lc1_q;
    logic [7:0]  offs_q;
    logic        ext_q, mem_we, mem_byte;
    logic [15:0] mem_addr, mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    mvdst_writeback i_mvdst_writeback (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_dst(mv_dst),
        .mv_src(mv_src), .mv_src_byte(mv_src_byte), .acc_rd_idx(acc_rd_idx),
        .acc_rd_data(acc_rd_data), .ap_q(ap_q), .sp_q(sp_q), .bp_q(bp_q),
        .offs_q(offs_q), .dp0_q(dp0_q), .dp1_q(dp1_q), .gr_q(gr_q),
        .lc0_q(lc0_q), .lc1_q(lc1_q), .ext_q(ext_q), .mem_we(mem_we),
        .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_acc(input string req, input logic [3:0] idx, input logic [15:0] exp);
        acc_rd_idx = idx;
        #1;
        chk(req, acc_rd_data, exp);
    endtask

    // One move; returns at the falling edge after the capturing edge.
    task automatic mv(input logic [6:0] code, input logic [15:0] val, input logic is_byte);
        @(negedge clk);
        mv_valid = 1'b1; mv_dst = code; mv_src = val; mv_src_byte = is_byte;
        @(negedge clk);
        mv_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 sp", sp_q, 16'h0);      chk("R1 bp", bp_q, 16'h0);
        chk("R1 offs", {8'h0, offs_q}, 16'h0);
        chk("R1 dp0", dp0_q, 16'h0);    chk("R1 dp1", dp1_q, 16'h0);
        chk("R1 gr", gr_q, 16'h0);      chk("R1 lc0", lc0_q, 16'h0);
        chk("R1 ap", {12'h0, ap_q}, 16'h0);
        chk("R1 ext", {15'h0, ext_q}, 16'h0);
        chk("R1 mem_we", {15'h0, mem_we}, 16'h0);
    endtask

    task automatic t_acc;
        mv(7'h19, 16'h1234, 1'b0);
        chk_acc("R4 A1 word", 4'd1, 16'h1234);
        mv(7'h79, 16'hFFAB, 1'b1);
        chk_acc("R2 byte zero fill A7", 4'd7, 16'h00AB);
        mv(7'h08, 16'hFF03, 1'b0);
        chk("R5 ap low bits / R2 low byte kept", {12'h0, ap_q}, 16'h0003);
        mv(7'h0A, 16'hBEEF, 1'b0);
        chk_acc("R5 active acc", 4'd3, 16'hBEEF);
        chk_acc("R5 other acc untouched", 4'd1, 16'h1234);
    endtask

    task automatic t_null;
        mv(7'h76, 16'hFFFF, 1'b0);
        chk("R3 null no mem", {15'h0, mem_we}, 16'h0);
        chk("R3 null gr", gr_q, 16'h0);
        chk("R3 null sp", sp_q, 16'h0);
        mv(7'h48, 16'h0009, 1'b0);
        chk("R3 unmodelled ap", {12'h0, ap_q}, 16'h0003);
        chk("R3 unmodelled mem", {15'h0, mem_we}, 16'h0);
    endtask

    task automatic t_gr;
        mv(7'h5E, 16'hA5C3, 1'b0);
        chk("R9 gr word", gr_q, 16'hA5C3);
        mv(7'h6E, 16'h7711, 1'b0);
        chk("R9 grl", gr_q, 16'hA511);
    endtask

    task automatic t_lc_sp;
        mv(7'h6D, 16'h1111, 1'b0);
        chk("R10 lc0", lc0_q, 16'h1111);
        mv(7'h7D, 16'h2222, 1'b0);
        chk("R10 lc1", lc1_q, 16'h2222);
        chk("R10 lc0 kept", lc0_q, 16'h1111);
        mv(7'h1D, 16'h0100, 1'b0);
        chk("R10 sp load", sp_q, 16'h0100);
    endtask

    task automatic t_push;
        mv(7'h0D, 16'hCAFE, 1'b0);
        chk("R6 sp inc", sp_q, 16'h0101);
        chk("R6 we", {15'h0, mem_we}, 16'h1);
        chk("R6 addr", mem_addr, 16'h0101);
        chk("R6 data", mem_wdata, 16'hCAFE);
        chk("R12 word flag", {15'h0, mem_byte}, 16'h0);
        @(negedge clk);
        chk("R12 single pulse", {15'h0, mem_we}, 16'h0);
    endtask

    task automatic t_frame;
        mv(7'h7E, 16'h2000, 1'b0);
        chk("R7 bp", bp_q, 16'h2000);
        mv(7'h3E, 16'h0005, 1'b0);
        chk("R7 offs", {8'h0, offs_q}, 16'h0005);
        mv(7'h0E, 16'h1234, 1'b0);
        chk("R7 plain addr", mem_addr, 16'h2005);
        chk("R7 plain offs", {8'h0, offs_q}, 16'h0005);
        mv(7'h1E, 16'h3377, 1'b1);
        chk("R7 inc offs", {8'h0, offs_q}, 16'h0006);
        chk("R7 inc addr", mem_addr, 16'h2006);
        chk("R12 byte flag", {15'h0, mem_byte}, 16'h1);
        chk("R12 byte data", mem_wdata, 16'h0077);
        mv(7'h2E, 16'h0001, 1'b0);
        chk("R7 dec addr", mem_addr, 16'h2005);
        mv(7'h3E, 16'h00FF, 1'b0);
        mv(7'h1E, 16'h0002, 1'b0);
        chk("R7 offs wrap", {8'h0, offs_q}, 16'h0000);
        chk("R7 wrap addr", mem_addr, 16'h2000);
    endtask

    task automatic t_dp;
        mv(7'h3F, 16'h4000, 1'b0);
        mv(7'h7F, 16'h5000, 1'b0);
        chk("R8 dp0 load", dp0_q, 16'h4000);
        chk("R8 dp1 load", dp1_q, 16'h5000);
        mv(7'h1F, 16'hAAAA, 1'b0);
        chk("R8 dp0 inc", dp0_q, 16'h4001);
        chk("R8 inc addr", mem_addr, 16'h4001);
        mv(7'h6F, 16'hBBBB, 1'b0);
        chk("R8 dp1 dec", dp1_q, 16'h4FFF);
        chk("R8 dec addr", mem_addr, 16'h4FFF);
        mv(7'h0F, 16'hCCCC, 1'b0);
        chk("R8 plain addr", mem_addr, 16'h4001);
        chk("R8 plain keeps dp0", dp0_q, 16'h4001);
    endtask

    task automatic t_ext;
        mv(7'h0B, 16'h009A, 1'b1);
        chk("R11 armed", {15'h0, ext_q}, 16'h1);
        mv(7'h29, 16'h0055, 1'b1);
        chk_acc("R4 R11 upper bank with prefix fill", 4'd10, 16'h9A55);
        chk_acc("R4 lower bank untouched", 4'd2, 16'h0000);
        chk("R11 consumed", {15'h0, ext_q}, 16'h0);
        mv(7'h29, 16'h0055, 1'b1);
        chk_acc("R11 after consume zero fill", 4'd2, 16'h0055);
        mv(7'h3B, 16'h0000, 1'b1);
        mv(7'h1E, 16'h00CD, 1'b1);
        chk("R9 grh", gr_q, 16'hCD11);
        chk("R9 grh offs kept", {8'h0, offs_q}, 16'h0000);
        chk("R9 grh no mem", {15'h0, mem_we}, 16'h0);
        mv(7'h1E, 16'h00EE, 1'b1);
        chk("R9 plain 0x1E is frame inc", {8'h0, offs_q}, 16'h0001);
        chk("R9 plain 0x1E gr kept", gr_q, 16'hCD11);
        mv(7'h0B, 16'h0044, 1'b1);
        mv(7'h76, 16'h0000, 1'b0);
        chk("R11 null consumes", {15'h0, ext_q}, 16'h0);
        mv(7'h39, 16'h0066, 1'b1);
        chk_acc("R11 lower bank after null", 4'd3, 16'h0066);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_acc();
        t_null();
        t_gr();
        t_lc_sp();
        t_push();
        t_frame();
        t_dp();
        t_ext();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule